// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit scratch and status words reached over a simple word-wide register bus. It decodes a 4 KiB byte window, keeps 512 words of storage selected by the byte address shifted right by two, and ignores the two lowest address bits, so every access moves a full word. Four words leave reset with fixed nonzero contents. Three status words always read back with bits 29:28 high, whatever was stored in them.

One byte offset, 0xF00, lies above the stored words and acts as a power command port. A write there is never stored. Its data decides whether the block raises a one-cycle system-reset request or a one-cycle shutdown request on the clock edge after the write. A small state machine produces the pulses. Its states are CMD_IDLE (no request), CMD_RESET (reset request high) and CMD_OFF (shutdown request high). Its transitions are:
- IDLE→RESET on a write of 1 or 2 to the command port.
- IDLE→OFF on a write of 3 to the command port.
- RESET/OFF→IDLE after one cycle when no new command arrives.
- RESET/OFF→RESET or RESET/OFF→OFF when another command write arrives in that cycle.

The platform logic that acts on the requests is outside this block.

Top module: `sysctl_regfile`

## Requirements
- R1: The word index is the byte address divided by four. Address bits 1:0 are ignored, so a write to 0x007 and a read of 0x004 reach the same word.
- R2: After reset the word at byte offset 0x100 holds 0x05F20121, 0x104 holds 0x00000002, 0x108 holds 0x05F30121 and 0x10C holds 0x05F40121. Every other word holds zero.
- R3: A write stores all 32 data bits at the clock edge where write-enable is high. Read data is registered at the edge where read-enable is high, and it holds its value while read-enable is low.
- R4: A write whose word index is 512 or more (byte offset 0x800 and up) is not stored and does not alias onto a lower word.
- R5: A read whose word index is 512 or more returns zero.
- R6: Reads of byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000. The stored value is unchanged. Offset 0x104 is not forced.
- R7: A write of data 1 or 2 to byte offset 0xF00 (bits 1:0 ignored) drives the reset request high for exactly the one cycle after that write's edge.
- R8: A write of data 3 to byte offset 0xF00 drives the shutdown request high for exactly the one cycle after that write's edge.
- R9: A write of any other data to 0xF00 raises neither request. A read of 0xF00 returns zero, because command writes are not stored.
- R10: The reset request and the shutdown request are never high together. Reset has priority.
- R11: A read and a write to the same word in the same cycle return the word's value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system-reset request |
| sys_off_req | output | 1 | One-cycle shutdown request |

## Verification
Stored data becomes visible one edge after the write edge. Read data appears one edge after the read-strobe edge. A request pulse appears one edge after the command write and is gone one edge later. The bench raises each strobe on a falling edge, lets one rising edge pass, and samples on the next falling edge. For commands it samples again one cycle later to show that the pulse has ended. The same-cycle read/write case is sampled after the single shared edge and must show the older value.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_RESET = 2'd1,
        CMD_OFF   = 2'd2
    } cmd_state_t;

    localparam logic [31:0] STATUS_FORCE = 32'h3000_0000;

    function automatic logic [31:0] word_reset_value(input int unsigned idx);
        case (idx)
            32'h40:  return 32'h05F2_0121;
            32'h41:  return 32'h0000_0002;
            32'h42:  return 32'h05F3_0121;
            32'h43:  return 32'h05F4_0121;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic word_is_status(input logic [31:0] idx);
        return (idx == 32'h40) || (idx == 32'h42) || (idx == 32'h43);
    endfunction

endpackage

// File: rtl/sysctl_store.sv
`timescale 1ns/1ps
module sysctl_store #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] word_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              in_range,
    output logic [DATA_W-1:0] rd_word
);
    import sysctl_pkg::*;

    localparam int IDX_W = $clog2(NUM_WORDS);

    logic [DATA_W-1:0] mem [NUM_WORDS];
    logic [IDX_W-1:0]  slot;

    assign in_range = (word_sel < ADDR_W'(NUM_WORDS));
    assign slot     = word_sel[IDX_W-1:0];
    assign rd_word  = mem[slot];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                mem[i] <= DATA_W'(word_reset_value(i));
            end
        end else if (wr_en && in_range) begin
            mem[slot] <= wdata;
        end
    end

    // R4
    no_alias_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && !in_range) |-> (mem[$past(slot)] == $past(rd_word)));

    // R3
    full_word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && in_range) |-> (mem[$past(slot)] == $past(wdata)));

endmodule

// File: rtl/sysctl_rd_port.sv
`timescale 1ns/1ps
module sysctl_rd_port #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              in_range,
    input  logic              is_status,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] rdata
);
    import sysctl_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (!in_range)      rdata <= '0;
            else if (is_status) rdata <= word | DATA_W'(STATUS_FORCE);
            else                rdata <= word;
        end
    end

    // R5
    out_of_range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && !in_range) |-> (rdata == '0));

    // R6
    status_bits_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && in_range && is_status) |-> (rdata[29:28] == 2'b11));

    // R3
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata));

endmodule

// File: rtl/sysctl_cmd_fsm.sv
`timescale 1ns/1ps
module sysctl_cmd_fsm #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int CMD_OFFSET = 'hF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] word_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              reset_req,
    output logic              off_req
);
    import sysctl_pkg::*;

    localparam logic [ADDR_W-1:0] CMD_WORD = ADDR_W'(CMD_OFFSET >> 2);

    cmd_state_t state_q, state_d;
    logic       cmd_hit;

    assign cmd_hit = wr_en && (word_sel == CMD_WORD);

    always_comb begin
        state_d = CMD_IDLE;
        if (cmd_hit) begin
            unique case (wdata)
                DATA_W'(1), DATA_W'(2): state_d = CMD_RESET;
                DATA_W'(3):             state_d = CMD_OFF;
                default:                state_d = CMD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        reset_req = 1'b0;
        off_req   = 1'b0;
        unique case (state_q)
            CMD_IDLE:  ;
            CMD_RESET: reset_req = 1'b1;
            CMD_OFF:   off_req   = 1'b1;
            default:   ;
        endcase
    end

    // R10
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reset_req, off_req}));

    // R7
    reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(cmd_hit && (wdata == DATA_W'(1) || wdata == DATA_W'(2))));

    // R8
    off_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |-> $past(cmd_hit && wdata == DATA_W'(3)));

endmodule

// File: rtl/sysctl_regfile.sv
`timescale 1ns/1ps
module sysctl_regfile #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int NUM_WORDS  = 512,
    parameter int CMD_OFFSET = 'hF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd_en,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_reset_req,
    output logic              sys_off_req
);
    import sysctl_pkg::*;

    logic [ADDR_W-1:0] word_sel;
    logic [DATA_W-1:0] rd_word;
    logic              in_range;
    logic              is_status;

    assign word_sel  = bus_addr >> 2;
    assign is_status = word_is_status(32'(word_sel));

    sysctl_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .word_sel(word_sel),
        .wdata(bus_wdata), .in_range(in_range), .rd_word(rd_word)
    );

    sysctl_rd_port #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_rd_en), .in_range(in_range),
        .is_status(is_status), .word(rd_word), .rdata(bus_rdata)
    );

    sysctl_cmd_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_OFFSET(CMD_OFFSET)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .word_sel(word_sel),
        .wdata(bus_wdata), .reset_req(sys_reset_req), .off_req(sys_off_req)
    );

endmodule

// File: tb/sysctl_regfile_tb.sv
`timescale 1ns/1ps
module sysctl_regfile_tb;

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read-check, 2 command-check
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;   // read value, or {reset,off} for commands
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 12'h000, 32'hA5A5_A5A5, 32'h0,         4'd3},
        '{2'd1, 12'h000, 32'h0,         32'hA5A5_A5A5, 4'd3},  // R3
        '{2'd0, 12'h007, 32'h1234_5678, 32'h0,         4'd1},
        '{2'd1, 12'h004, 32'h0,         32'h1234_5678, 4'd1},  // R1
        '{2'd0, 12'h800, 32'hDEAD_BEEF, 32'h0,         4'd4},
        '{2'd1, 12'h000, 32'h0,         32'hA5A5_A5A5, 4'd4},  // R4
        '{2'd1, 12'h800, 32'h0,         32'h0,         4'd5},  // R5
        '{2'd1, 12'hFFC, 32'h0,         32'h0,         4'd5},  // R5
        '{2'd0, 12'h100, 32'h0,         32'h0,         4'd6},
        '{2'd1, 12'h100, 32'h0,         32'h3000_0000, 4'd6},  // R6
        '{2'd0, 12'h104, 32'h0,         32'h0,         4'd6},
        '{2'd1, 12'h104, 32'h0,         32'h0,         4'd6},  // R6
        '{2'd0, 12'h10C, 32'hFFFF_FFFF, 32'h0,         4'd6},
        '{2'd1, 12'h10D, 32'h0,         32'hFFFF_FFFF, 4'd6},  // R6
        '{2'd2, 12'hF00, 32'd1,         32'd2,         4'd7},  // R7
        '{2'd2, 12'hF02, 32'd2,         32'd2,         4'd7},  // R7
        '{2'd2, 12'hF00, 32'd3,         32'd1,         4'd8},  // R8
        '{2'd2, 12'hF00, 32'd0,         32'd0,         4'd9},  // R9
        '{2'd2, 12'hF00, 32'd4,         32'd0,         4'd9},  // R9
        '{2'd1, 12'hF00, 32'h0,         32'h0,         4'd9}   // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rdata;
    logic        sys_reset_req;
    logic        sys_off_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sysctl_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
        .sys_reset_req(sys_reset_req), .sys_off_req(sys_off_req)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input int req);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd_en = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic do_cmd(input logic [11:0] a, input logic [31:0] d,
                          input logic [1:0] exp, input int req);
        do_write(a, d);
        check(req, {30'd0, sys_reset_req, sys_off_req}, {30'd0, exp});
        @(negedge clk);
        // R10 and single-cycle pulse: both low one cycle later
        check(req, {30'd0, sys_reset_req, sys_off_req}, 32'd0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(2, {30'd0, sys_reset_req, sys_off_req}, 32'd0);  // R2 outputs idle
        check(2, bus_rdata, 32'd0);                            // R2 read data
        rst_n = 1'b1;
        // R2 reset contents
        do_read(12'h100, 32'h35F2_0121, 2);
        do_read(12'h104, 32'h0000_0002, 2);
        do_read(12'h108, 32'h35F3_0121, 2);
        do_read(12'h10C, 32'h35F4_0121, 2);
        do_read(12'h1FC, 32'h0, 2);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: do_write(VEC[i].addr, VEC[i].data);
                2'd1: do_read(VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
                default: do_cmd(VEC[i].addr, VEC[i].data, VEC[i].exp[1:0], int'(VEC[i].req));
            endcase
        end

        // R3: read data holds while the strobe is low
        do_read(12'h004, 32'h1234_5678, 3);
        @(negedge clk); bus_addr = 12'h000;
        @(negedge clk);
        check(3, bus_rdata, 32'h1234_5678);

        // R11: same-cycle read and write return the older value
        @(negedge clk);
        bus_addr = 12'h014; bus_wdata = 32'h1111_1111;
        bus_wr_en = 1'b1; bus_rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0; bus_rd_en = 1'b0;
        check(11, bus_rdata, 32'h0);
        do_read(12'h014, 32'h1111_1111, 11);

        // R7 R8 R10: back-to-back commands, each pulse in its own cycle
        @(negedge clk);
        bus_addr = 12'hF00; bus_wdata = 32'd3; bus_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wdata = 32'd1;
        check(8, {30'd0, sys_reset_req, sys_off_req}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0;
        check(7, {30'd0, sys_reset_req, sys_off_req}, 32'd2);
        @(negedge clk);
        check(10, {30'd0, sys_reset_req, sys_off_req}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule